// File: doc/BRIEF.md
# Sector Write-Protection Arbiter

This block decides, cycle by cycle, whether a program or erase request aimed at a small four-sector serial flash may proceed. It merges two protection sources: a hardware write-protect pin (active low) and a software enable that one-cycle command pulses set and clear. It applies the merged state to a four-byte protection register image, which a holding register outside the block supplies. Sector 0 is split into two regions: a small region of 8 pages and a larger region covering the rest of that sector.

The software enable is sticky. Once it is set, raising the pin does not remove protection, and only a disable pulse given while the pin is high clears it. While the pin holds protection, the register image may not be erased or reprogrammed. While an internal erase is busy, a change on the pin is held back until the erase finishes. Chip erase is never refused; the allow mask tells the array which regions it may clear.

Top module: `sector_guard`

## Requirements
- R1: A synchronous active-high `rst` clears the software enable and the held pin state. With `wp_n` high and `busy` low after reset, `prot_active` is 0 and `allow_mask` is all ones.
- R2: The effective pin lock is `~wp_n` while `busy` is low. A set lock drives `prot_active` and `reg_veto` to 1 in the same cycle. With the software enable clear, returning `wp_n` high drops both to 0 in that cycle.
- R3: A `prot_on` pulse sets the software enable from the next cycle. This happens whatever the pin level. Once the enable is set, `prot_active` stays 1 through any later pin low and high changes.
- R4: A `prot_off` pulse clears the software enable from the next cycle only while the effective pin lock is clear. While the lock is set, the pulse is ignored. When both pulses arrive in the same cycle, `prot_on` wins.
- R5: The register image `prot_img` holds byte k at bits 8k+7:8k. Byte 0 bits 7:6 guard region 0 and bits 5:4 guard region 1. Bytes 1 to 3 guard sectors 1 to 3, which are regions 2 to 4. A non-zero field counts as protected: 00h is unprotected and FFh is protected.
- R6: The target region comes from `req_page` as follows: pages 0 to 7 give region 0 and pages 8 to 127 give region 1. From page 128 up, page bits 8:7 (values 1 to 3) give regions 2 to 4.
- R7: For `req_op` values 0 (page program), 1 (page erase), 2 (block erase) and 3 (sector erase), `req_deny` is 1 exactly when `req_valid`, `prot_active` and the target region's guard are all 1. The output is combinational and valid in the cycle the request is presented.
- R8: `allow_mask[r]` is 0 exactly when `prot_active` is 1 and region r is guarded. `req_op` 4 (chip erase) is never denied; the array erases only the regions that `allow_mask` allows.
- R9: For `req_op` 5 (register erase) and 6 (register program), `req_deny` equals the effective pin lock whenever `req_valid` is 1. `reg_veto` always shows that lock.
- R10: While `busy` is 1, the effective pin lock holds the value of `~wp_n` from the last cycle in which `busy` was 0. The live pin takes effect again in the cycle `busy` falls.
- R11: `req_op` 7 and any cycle with `req_valid` low never give `req_deny`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Hardware write-protect pin, low = protect |
| prot_on | input | 1 | One-cycle software enable-protection pulse |
| prot_off | input | 1 | One-cycle software disable-protection pulse |
| prot_img | input | 32 | Protection register image, byte k at bits 8k+7:8k |
| busy | input | 1 | Internal program/erase in progress |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Requested operation code |
| req_page | input | 9 | Page address of the request |
| prot_active | output | 1 | Overall protection enabled |
| allow_mask | output | 5 | Per-region allow bits, regions 0 to 4 |
| req_deny | output | 1 | Veto of the presented request |
| reg_veto | output | 1 | Veto of protection-register modification |

## Verification
The assertions take for granted that every input is driven to a known value from the first clock edge and changes only away from the rising edge. They also rely on `prot_on` and `prot_off` being level inputs sampled once per cycle, so that one pulse may overlap with `busy` or with the other pulse. The freeze property additionally assumes that `busy` is low during the reset cycle. The stimulus drives all inputs on the falling edge and holds `busy` low through reset. It runs directed phases over every pin, pulse and busy ordering, then a long stretch of random traffic.

// File: rtl/sg_pkg.sv
`timescale 1ns/1ps
package sg_pkg;
    localparam int NUM_SECT     = 4;
    localparam int PAGE_W       = 9;
    localparam int SUB0A_PAGES  = 8;
    localparam int SECT_PAGES   = 128;
    localparam int NREG         = NUM_SECT + 1;
    localparam int RIDX_W       = $clog2(NREG);
    localparam int IMG_W        = NUM_SECT * 8;
    localparam int SECT_SH      = $clog2(SECT_PAGES);

    localparam logic [PAGE_W-1:0] SUB0A_END = PAGE_W'(SUB0A_PAGES);
    localparam logic [PAGE_W-1:0] SECT_END  = PAGE_W'(SECT_PAGES);

    typedef enum logic [2:0] {
        OP_PAGE_PROG   = 3'd0,
        OP_PAGE_ERASE  = 3'd1,
        OP_BLOCK_ERASE = 3'd2,
        OP_SECT_ERASE  = 3'd3,
        OP_CHIP_ERASE  = 3'd4,
        OP_REG_ERASE   = 3'd5,
        OP_REG_PROG    = 3'd6,
        OP_NOP         = 3'd7
    } sg_op_e;

    typedef struct packed {
        logic              valid;
        sg_op_e            op;
        logic [PAGE_W-1:0] page;
    } sg_req_t;

    typedef struct packed {
        logic sw_en;
        logic hw_lock;
    } sg_state_t;

    // Map a page address onto a protection region index.
    function automatic logic [RIDX_W-1:0] region_of(input logic [PAGE_W-1:0] pg);
        logic [PAGE_W-1:0] hi;
        hi = pg >> SECT_SH;
        if (pg < SUB0A_END)
            return '0;
        else if (pg < SECT_END)
            return RIDX_W'(1);
        else
            return RIDX_W'(hi + PAGE_W'(1));
    endfunction
endpackage

// File: rtl/sg_pin_hold.sv
`timescale 1ns/1ps
module sg_pin_hold (
    input  logic clk,
    input  logic rst,
    input  logic wp_n,
    input  logic busy,
    output logic hw_lock
);
    logic held_lock;

    always_ff @(posedge clk) begin
        if (rst)
            held_lock <= 1'b0;
        else if (!busy)
            held_lock <= ~wp_n;
    end

    // A running erase keeps the pin level it started with.
    assign hw_lock = busy ? held_lock : ~wp_n;
endmodule

// File: rtl/sg_soft_latch.sv
`timescale 1ns/1ps
module sg_soft_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_pulse,
    input  logic hw_lock,
    output logic sw_en
);
    always_ff @(posedge clk) begin
        if (rst)
            sw_en <= 1'b0;
        else if (set_pulse)
            sw_en <= 1'b1;
        else if (clr_pulse && !hw_lock)
            sw_en <= 1'b0;
    end
endmodule

// File: rtl/sg_region_map.sv
`timescale 1ns/1ps
module sg_region_map
    import sg_pkg::*;
(
    input  logic [IMG_W-1:0] img,
    output logic [NREG-1:0]  guard
);
    // Sector 0 splits into two regions, each with a two-bit field.
    assign guard[0] = |img[7:6];
    assign guard[1] = |img[5:4];

    for (genvar s = 1; s < NUM_SECT; s++) begin : g_sect
        assign guard[s+1] = |img[8*s +: 8];
    end
endmodule

// File: rtl/sector_guard.sv
`timescale 1ns/1ps
module sector_guard
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              prot_on,
    input  logic              prot_off,
    input  logic [IMG_W-1:0]  prot_img,
    input  logic              busy,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PAGE_W-1:0] req_page,
    output logic              prot_active,
    output logic [NREG-1:0]   allow_mask,
    output logic              req_deny,
    output logic              reg_veto
);
    localparam int PAD_W = 2 ** RIDX_W;

    sg_state_t          st;
    logic               hw_lock;
    logic               sw_en;
    logic [NREG-1:0]    guard;
    logic [PAD_W-1:0]   guard_pad;
    logic [RIDX_W-1:0]  tgt;
    sg_req_t            req;

    sg_pin_hold u_pin (
        .clk     (clk),
        .rst     (rst),
        .wp_n    (wp_n),
        .busy    (busy),
        .hw_lock (hw_lock)
    );

    sg_soft_latch u_soft (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (prot_on),
        .clr_pulse (prot_off),
        .hw_lock   (hw_lock),
        .sw_en     (sw_en)
    );

    sg_region_map u_map (
        .img   (prot_img),
        .guard (guard)
    );

    assign st.sw_en   = sw_en;
    assign st.hw_lock = hw_lock;

    assign req.valid = req_valid;
    assign req.op    = sg_op_e'(req_op);
    assign req.page  = req_page;

    assign prot_active = st.sw_en | st.hw_lock;
    assign reg_veto    = st.hw_lock;
    assign allow_mask  = ~(guard & {NREG{prot_active}});

    assign guard_pad = PAD_W'(guard);
    assign tgt       = region_of(req.page);

    always_comb begin
        req_deny = 1'b0;
        if (req.valid) begin
            unique case (req.op)
                OP_PAGE_PROG, OP_PAGE_ERASE,
                OP_BLOCK_ERASE, OP_SECT_ERASE: req_deny = prot_active & guard_pad[tgt];
                OP_REG_ERASE, OP_REG_PROG:     req_deny = st.hw_lock;
                OP_CHIP_ERASE, OP_NOP:         req_deny = 1'b0;
                default:                       req_deny = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sg_checker.sv
`timescale 1ns/1ps
module sg_checker
    import sg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wp_n,
    input logic              prot_on,
    input logic              prot_off,
    input logic              busy,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              prot_active,
    input logic [NREG-1:0]   allow_mask,
    input logic              req_deny,
    input logic              reg_veto,
    input logic              sw_en
);
    // R2
    a_r2_pin_low_protects: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wp_n) |-> (prot_active && reg_veto));

    // R2
    a_r2_pin_high_frees_reg: assert property (@(posedge clk) disable iff (rst)
        (!busy && wp_n) |-> !reg_veto);

    // R3
    a_r3_enable_sticks: assert property (@(posedge clk) disable iff (rst)
        prot_on |=> (prot_active && sw_en));

    // R4
    a_r4_disable_blocked: assert property (@(posedge clk) disable iff (rst)
        (prot_off && reg_veto && sw_en) |=> sw_en);

    // R8
    a_r8_chip_never_denied: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'(OP_CHIP_ERASE)) |-> !req_deny);

    // R8
    a_r8_unprotected_allows_all: assert property (@(posedge clk) disable iff (rst)
        !prot_active |-> (allow_mask == '1));

    // R9
    a_r9_reg_write_vetoed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && reg_veto &&
         (req_op == 3'(OP_REG_ERASE) || req_op == 3'(OP_REG_PROG))) |-> req_deny);

    // R10
    a_r10_busy_freezes_pin: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> $stable(reg_veto));

    // R11
    a_r11_idle_no_deny: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == 3'(OP_NOP)) |-> !req_deny);
endmodule

bind sector_guard sg_checker i_sg_checker (
    .clk         (clk),
    .rst         (rst),
    .wp_n        (wp_n),
    .prot_on     (prot_on),
    .prot_off    (prot_off),
    .busy        (busy),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .prot_active (prot_active),
    .allow_mask  (allow_mask),
    .req_deny    (req_deny),
    .reg_veto    (reg_veto),
    .sw_en       (sw_en)
);

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        wp_n;
    logic        prot_on;
    logic        prot_off;
    logic [31:0] prot_img;
    logic        busy;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [8:0]  req_page;
    logic        prot_active;
    logic [4:0]  allow_mask;
    logic        req_deny;
    logic        reg_veto;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Reference state
    bit m_sw;
    bit m_hold;

    always #2.5 clk = ~clk;

    sector_guard i_sector_guard (
        .clk(clk), .rst(rst), .wp_n(wp_n), .prot_on(prot_on), .prot_off(prot_off),
        .prot_img(prot_img), .busy(busy), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .prot_active(prot_active), .allow_mask(allow_mask),
        .req_deny(req_deny), .reg_veto(reg_veto)
    );

    function automatic bit guarded(int r, logic [31:0] img);
        case (r)
            0: return img[7:6] != 2'b00;
            1: return img[5:4] != 2'b00;
            2: return img[15:8] != 8'h00;
            3: return img[23:16] != 8'h00;
            default: return img[31:24] != 8'h00;
        endcase
    endfunction

    function automatic int region(int pg);
        if (pg < 8)   return 0;
        if (pg < 128) return 1;
        return pg / 128 + 1;
    endfunction

    task automatic cmp(string tag, string what, int got, int exp);
        if (got != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Compare this cycle, then advance the model across the edge.
    task automatic step(string tag);
        bit eff, prot, deny;
        int am;
        #1;
        eff  = busy ? m_hold : !wp_n;
        prot = m_sw || eff;
        am   = 0;
        for (int r = 0; r < 5; r++)
            if (!(prot && guarded(r, prot_img))) am |= (1 << r);
        deny = 0;
        if (req_valid) begin
            if (req_op <= 3)                     deny = prot && guarded(region(int'(req_page)), prot_img);
            else if (req_op == 5 || req_op == 6) deny = eff;
        end
        vectors++;
        cmp(tag, "prot_active", int'(prot_active), int'(prot));
        cmp(tag, "allow_mask",  int'(allow_mask),  am);
        cmp(tag, "req_deny",    int'(req_deny),    int'(deny));
        cmp(tag, "reg_veto",    int'(reg_veto),    int'(eff));
        @(posedge clk);
        if (rst) begin
            m_sw = 0; m_hold = 0;
        end else begin
            if (prot_on)              m_sw = 1;
            else if (prot_off && !eff) m_sw = 0;
            if (!busy) m_hold = !wp_n;
        end
        @(negedge clk);
        prot_on  = 0;
        prot_off = 0;
    endtask

    task automatic req(int op, int pg);
        req_valid = 1;
        req_op    = 3'(op);
        req_page  = 9'(pg);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int pages[10] = '{0, 7, 8, 127, 128, 255, 256, 383, 384, 511};
        rst = 1; wp_n = 1; prot_on = 0; prot_off = 0; prot_img = 32'hFFFF_FFFF;
        busy = 0; req_valid = 0; req_op = 3'd7; req_page = '0;
        @(negedge clk);
        @(posedge clk); m_sw = 0; m_hold = 0;
        @(negedge clk);
        step("R1");
        rst = 0;
        // R1: clean state after reset
        repeat (2) step("R1");

        // R2: pin low protects and freezes the register image
        wp_n = 0; req(0, 5);   step("R2");
        req(7, 5);             step("R11");
        wp_n = 1; req(0, 5);   step("R2");
        req_valid = 0; req_op = 3'd0; step("R11");

        // R3: enable pulse is sticky across pin changes
        prot_on = 1; step("R3");
        step("R3");
        wp_n = 0; step("R3");
        wp_n = 1; step("R3");
        // R4: disable ignored while pin low, effective when high
        wp_n = 0; prot_off = 1; step("R4");
        wp_n = 1; step("R4");
        prot_off = 1; step("R4");
        step("R4");
        prot_on = 1; prot_off = 1; step("R4");
        step("R4");

        // R5, R6, R7: region encoding and page decode
        foreach (prot_img[i]) ;
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: prot_img = 32'h0000_00C0;
                1: prot_img = 32'h0000_0030;
                2: prot_img = 32'h0000_FF00;
                3: prot_img = 32'h00FF_0000;
                4: prot_img = 32'hFF00_0000;
                default: prot_img = 32'h0100_0140;
            endcase
            for (int p = 0; p < 10; p++) begin
                req(p % 4, pages[p]);
                step(p < 5 ? "R6" : "R7");
            end
            req_valid = 0; step("R5");
        end

        // R8: chip erase never refused, mask reports erasable regions
        prot_img = 32'h00FF_0030;
        req(4, 0);   step("R8");
        prot_img = 32'hFFFF_FFFF;
        req(4, 300); step("R8");

        // R9: register writes follow the pin only
        req(5, 0); step("R9");
        wp_n = 0; req(5, 0); step("R9");
        req(6, 0); step("R9");
        wp_n = 1; req(6, 0); step("R9");

        // R10: pin changes are held back during busy
        prot_off = 1; step("R10");
        busy = 1; step("R10");
        wp_n = 0; req(6, 0); step("R10");
        req(1, 200); step("R10");
        busy = 0; step("R10");
        busy = 1; step("R10");
        wp_n = 1; prot_off = 1; step("R10");
        step("R10");
        busy = 0; step("R10");

        // R7: mixed traffic
        for (int n = 0; n < 400; n++) begin
            wp_n      = ($urandom_range(0, 3) != 0);
            busy      = ($urandom_range(0, 4) == 0);
            prot_on   = ($urandom_range(0, 9) == 0);
            prot_off  = ($urandom_range(0, 6) == 0);
            req_valid = $urandom_range(0, 1);
            req_op    = 3'($urandom_range(0, 7));
            req_page  = 9'($urandom_range(0, 511));
            if ($urandom_range(0, 15) == 0) prot_img = $urandom;
            step("R7");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule